// File: doc/BRIEF.md
# Passive SPI Bus Monitor

This block observes an SPI bus without ever driving it. A fast system clock oversamples the serial clock, both data lines and an optional chip-select line. On every sampling edge of the serial clock it takes one bit from each data line. The bits build up a host-to-device word and a device-to-host word side by side. When the configured number of bits has arrived, the block presents both words together in a single-cycle result pulse and advances a running word counter.

Chip-select may be absent. A `cs_present` input tells the block whether the line is wired. When it is wired, every level change produces its own single-cycle event carrying the previous and new level. That event also discards any partly gathered word. A word whose first bit was taken while chip-select was inactive is flagged in its result.

Clock polarity, clock phase, chip-select polarity, bit order and word length are all runtime inputs. This lets one instance follow devices that use different bus conventions.

Top module: `spi_bus_monitor`

## Requirements
- R1: With the clock-polarity and clock-phase inputs forming mode {cpol,cpha} (0=00, 1=01, 2=10, 3=11), bits are taken on rising SCK edges in modes 0 and 3 and on falling SCK edges in modes 1 and 2. MOSI and MISO are sampled on the same edge.
- R2: With `cfg_lsb_first`=0, the n-th bit received (counting from 0) lands at bit position len-1-n of the result word. With `cfg_lsb_first`=1, it lands at position n.
- R3: The word length `cfg_word_len` accepts 1 to WORD_W (default 64). A value of 0 acts as 1, and a value above WORD_W acts as WORD_W. Result bits at or above the length read 0.
- R4: After the len-th bit, `data_valid` pulses high for exactly one cycle together with `mosi_word`, `miso_word` and `cs_warn`. `word_count` rises by one in that same cycle and holds its value in every other cycle. No result appears without a completed word.
- R5: While `cs_present`=1, each change of the chip-select level produces a single-cycle `cs_event` whose `cs_old` and `cs_new` give the levels before and after. While `cs_present`=0, chip-select changes produce no event and do not disturb a word in progress.
- R6: A chip-select change with `cs_present`=1 drops the bits already gathered, so the next result holds only bits sampled after the change.
- R7: Chip-select counts as active at level 0 when `cfg_cs_active_high`=0, and at level 1 when it is 1. `cs_warn` is 1 in a result exactly when `cs_present`=1 and chip-select was inactive as that word's first bit was sampled.
- R8: The warning does not carry over. A word started with chip-select active reports `cs_warn`=0, even if the previous word was flagged. `cs_warn` is never high outside a `data_valid` cycle.
- R9: After reset, `data_valid`, `cs_event` and `cs_warn` are 0 and `word_count` is 0.
- R10: Data-line changes while SCK is held, and SCK edges of the non-sampling direction, add no bits to a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Clock polarity (idle level of SCK) |
| cfg_cpha | input | 1 | Clock phase |
| cfg_cs_active_high | input | 1 | 1: chip-select active at level 1 |
| cfg_lsb_first | input | 1 | 1: first received bit is bit 0 |
| cfg_word_len | input | 7 | Bits per word, clamped to 1..WORD_W |
| cs_present | input | 1 | 1: chip-select line is wired |
| bus_sck | input | 1 | Observed serial clock |
| bus_mosi | input | 1 | Observed host-to-device data |
| bus_miso | input | 1 | Observed device-to-host data |
| bus_cs | input | 1 | Observed chip-select |
| data_valid | output | 1 | One-cycle pulse: word complete |
| mosi_word | output | 64 | Completed host-to-device word |
| miso_word | output | 64 | Completed device-to-host word |
| cs_warn | output | 1 | Word started with chip-select inactive |
| cs_event | output | 1 | One-cycle pulse: chip-select changed |
| cs_old | output | 1 | Chip-select level before the change |
| cs_new | output | 1 | Chip-select level after the change |
| word_count | output | 16 | Completed words since reset (wraps) |

## Verification
Words are sent in all four clock modes, with both bit orders and with lengths of 1, 8, 12, 16 and 64. Each data line carries a different value, so any mix-up between them is seen. The out-of-range lengths 0 and 100 show whether clamping is done. A word is cut short by a chip-select pulse to show that stale bits are dropped. Words are started with chip-select inactive under both polarities to separate the warning from the bare line level. Chip-select is toggled with `cs_present` low in the middle of a word, to show that the word survives and no event is raised. Data-line noise while SCK is held idle shows whether stray bits are counted.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;

    typedef struct packed {
        logic sck;
        logic mosi;
        logic miso;
        logic cs;
    } pins_t;

    typedef enum logic [1:0] {
        MODE0 = 2'd0,
        MODE1 = 2'd1,
        MODE2 = 2'd2,
        MODE3 = 2'd3
    } spi_mode_e;

    function automatic spi_mode_e mode_of(input logic cpol, input logic cpha);
        return spi_mode_e'({cpol, cpha});
    endfunction

    function automatic logic samples_on_rise(input spi_mode_e m);
        return (m == MODE0) || (m == MODE3);
    endfunction

    function automatic logic cs_is_idle(input logic level, input logic active_high);
        return active_high ? !level : level;
    endfunction

endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mon_frontend.sv
module spi_mon_frontend
    import spi_mon_pkg::*;
#(
    parameter int PRIME_CYCLES = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t cur,
    input  logic  cfg_cpol,
    input  logic  cfg_cpha,
    output logic  bit_strobe,
    output logic  cs_toggle,
    output logic  cs_prev
);
    localparam int PW = $clog2(PRIME_CYCLES + 1);

    logic [PW-1:0] prime_cnt;
    logic          primed;
    pins_t         prev;
    logic          rise, fall, want_rise;

    assign primed = (prime_cnt == PW'(PRIME_CYCLES));

    always_ff @(posedge clk) begin
        if (rst) begin
            prime_cnt <= '0;
            prev      <= '0;
        end else begin
            prev <= cur;
            if (!primed) prime_cnt <= prime_cnt + PW'(1);
        end
    end

    always_comb begin
        rise       = !prev.sck && cur.sck;
        fall       = prev.sck && !cur.sck;
        want_rise  = samples_on_rise(mode_of(cfg_cpol, cfg_cpha));
        bit_strobe = primed && (want_rise ? rise : fall);
        cs_toggle  = primed && (prev.cs != cur.cs);
        cs_prev    = prev.cs;
    end

    // R1: one sampling direction cannot fire in two consecutive cycles
    a_r1_strobe_gap: assert property (@(posedge clk) disable iff (rst)
        bit_strobe |=> !bit_strobe);
endmodule

// File: rtl/spi_mon_assembler.sv
module spi_mon_assembler
    import spi_mon_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int LEN_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_strobe,
    input  logic              mosi_bit,
    input  logic              miso_bit,
    input  logic              cs_level,
    input  logic              cs_clear,
    input  logic              cs_present,
    input  logic              cfg_lsb_first,
    input  logic              cfg_cs_active_high,
    input  logic [LEN_W-1:0]  eff_len,
    output logic              word_valid,
    output logic [WORD_W-1:0] mosi_word,
    output logic [WORD_W-1:0] miso_word,
    output logic              word_warn
);
    typedef struct packed {
        logic [LEN_W-1:0]  cnt;
        logic [WORD_W-1:0] mosi;
        logic [WORD_W-1:0] miso;
        logic              warn;
    } acc_t;

    acc_t              acc, base, nxt;
    logic [LEN_W-1:0]  pos;
    logic [WORD_W-1:0] mask;
    logic              done;

    always_comb begin
        base = cs_clear ? '0 : acc;
        nxt  = base;
        done = 1'b0;
        pos  = cfg_lsb_first ? base.cnt : (eff_len - LEN_W'(1) - base.cnt);
        mask = {{(WORD_W-1){1'b0}}, 1'b1} << pos;
        if (bit_strobe) begin
            if (base.cnt == '0)
                nxt.warn = cs_present && cs_is_idle(cs_level, cfg_cs_active_high);
            if (mosi_bit) nxt.mosi = base.mosi | mask;
            if (miso_bit) nxt.miso = base.miso | mask;
            nxt.cnt = base.cnt + LEN_W'(1);
            done    = (nxt.cnt >= eff_len);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            word_valid <= 1'b0;
            mosi_word  <= '0;
            miso_word  <= '0;
            word_warn  <= 1'b0;
        end else begin
            word_valid <= done;
            word_warn  <= done && nxt.warn;
            if (done) begin
                mosi_word <= nxt.mosi;
                miso_word <= nxt.miso;
                acc       <= '0;
            end else begin
                acc <= nxt;
            end
        end
    end

    // R6: a chip-select change with no bit in the same cycle leaves an empty word
    a_r6_clear_on_cs: assert property (@(posedge clk) disable iff (rst)
        (cs_clear && !bit_strobe) |=> (acc.cnt == '0 && acc.mosi == '0 && acc.miso == '0));
    // R4: the result strobe lasts one cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
    // R8: the warning only travels with a result
    a_r8_warn_with_word: assert property (@(posedge clk) disable iff (rst)
        word_warn |-> word_valid);
endmodule

// File: rtl/spi_bus_monitor.sv
module spi_bus_monitor
    import spi_mon_pkg::*;
#(
    parameter int WORD_W      = 64,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_cs_active_high,
    input  logic              cfg_lsb_first,
    input  logic [LEN_W-1:0]  cfg_word_len,
    input  logic              cs_present,
    input  logic              bus_sck,
    input  logic              bus_mosi,
    input  logic              bus_miso,
    input  logic              bus_cs,
    output logic              data_valid,
    output logic [WORD_W-1:0] mosi_word,
    output logic [WORD_W-1:0] miso_word,
    output logic              cs_warn,
    output logic              cs_event,
    output logic              cs_old,
    output logic              cs_new,
    output logic [CNT_W-1:0]  word_count
);
    pins_t            raw, synced;
    logic             bit_strobe, cs_toggle, cs_prev, cs_clear;
    logic [LEN_W-1:0] eff_len;

    assign raw = '{sck: bus_sck, mosi: bus_mosi, miso: bus_miso, cs: bus_cs};

    spi_mon_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    spi_mon_frontend #(.PRIME_CYCLES(SYNC_STAGES + 1)) u_front (
        .clk        (clk),
        .rst        (rst),
        .cur        (synced),
        .cfg_cpol   (cfg_cpol),
        .cfg_cpha   (cfg_cpha),
        .bit_strobe (bit_strobe),
        .cs_toggle  (cs_toggle),
        .cs_prev    (cs_prev)
    );

    always_comb begin
        if (cfg_word_len == '0)               eff_len = LEN_W'(1);
        else if (cfg_word_len > LEN_W'(WORD_W)) eff_len = LEN_W'(WORD_W);
        else                                  eff_len = cfg_word_len;
    end

    assign cs_clear = cs_present && cs_toggle;

    spi_mon_assembler #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_asm (
        .clk                (clk),
        .rst                (rst),
        .bit_strobe         (bit_strobe),
        .mosi_bit           (synced.mosi),
        .miso_bit           (synced.miso),
        .cs_level           (synced.cs),
        .cs_clear           (cs_clear),
        .cs_present         (cs_present),
        .cfg_lsb_first      (cfg_lsb_first),
        .cfg_cs_active_high (cfg_cs_active_high),
        .eff_len            (eff_len),
        .word_valid         (data_valid),
        .mosi_word          (mosi_word),
        .miso_word          (miso_word),
        .word_warn          (cs_warn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_event   <= 1'b0;
            cs_old     <= 1'b0;
            cs_new     <= 1'b0;
            word_count <= '0;
        end else begin
            cs_event <= cs_clear;
            if (cs_clear) begin
                cs_old <= cs_prev;
                cs_new <= synced.cs;
            end
            if (bit_strobe && !data_valid && u_asm.done)
                word_count <= word_count + CNT_W'(1);
        end
    end

    // R4: counter steps exactly with each result
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> word_count == $past(word_count) + CNT_W'(1));
    a_r4_count_hold: assert property (@(posedge clk) disable iff (rst)
        !data_valid |-> word_count == $past(word_count));
    // R5: an event reports a real level change
    a_r5_event_levels: assert property (@(posedge clk) disable iff (rst)
        cs_event |-> cs_old != cs_new);
    // R5: no event while chip-select is declared absent
    a_r5_absent_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(cs_present) |-> !cs_event);
endmodule

// File: tb/spi_bus_monitor_tb.sv
module spi_bus_monitor_tb;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_active_high = 1'b0, cfg_lsb_first = 1'b0;
    logic [6:0]  cfg_word_len = 7'd8;
    logic        cs_present = 1'b1;
    logic        bus_sck = 1'b0, bus_mosi = 1'b0, bus_miso = 1'b0, bus_cs = 1'b1;
    logic        data_valid, cs_warn, cs_event, cs_old, cs_new;
    logic [63:0] mosi_word, miso_word;
    logic [15:0] word_count;

    int checks = 0;
    int failures = 0;
    int words_pushed = 0;
    bit done = 1'b0;

    logic [63:0] q_mosi[$];
    logic [63:0] q_miso[$];
    bit          q_warn[$];
    string       q_tag[$];
    bit          qe_old[$];
    bit          qe_new[$];

    always #10 clk = ~clk;

    spi_bus_monitor u_dut (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_cs_active_high(cfg_cs_active_high), .cfg_lsb_first(cfg_lsb_first),
        .cfg_word_len(cfg_word_len), .cs_present(cs_present),
        .bus_sck(bus_sck), .bus_mosi(bus_mosi), .bus_miso(bus_miso), .bus_cs(bus_cs),
        .data_valid(data_valid), .mosi_word(mosi_word), .miso_word(miso_word),
        .cs_warn(cs_warn), .cs_event(cs_event), .cs_old(cs_old), .cs_new(cs_new),
        .word_count(word_count)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] lenmask(input int len);
        return (len >= 64) ? {64{1'b1}} : ((64'd1 << len) - 64'd1);
    endfunction

    task automatic push_word(input logic [63:0] mo, input logic [63:0] mi, input int len,
                             input bit warn, input string tag);
        q_mosi.push_back(mo & lenmask(len));
        q_miso.push_back(mi & lenmask(len));
        q_warn.push_back(warn);
        q_tag.push_back(tag);
        words_pushed++;
    endtask

    task automatic send_bits(input logic [63:0] mo, input logic [63:0] mi,
                             input int first, input int count, input int len);
        for (int i = first; i < first + count; i++) begin
            int idx;
            idx = cfg_lsb_first ? i : len - 1 - i;
            if (!cfg_cpha) begin
                bus_mosi = mo[idx]; bus_miso = mi[idx];
                idle(HALF);
                bus_sck = ~bus_sck;
                idle(HALF);
                bus_sck = ~bus_sck;
            end else begin
                bus_sck = ~bus_sck;
                bus_mosi = mo[idx]; bus_miso = mi[idx];
                idle(HALF);
                bus_sck = ~bus_sck;
                idle(HALF);
            end
        end
        idle(HALF);
    endtask

    task automatic word(input logic [63:0] mo, input logic [63:0] mi, input int len,
                        input bit warn, input string tag);
        push_word(mo, mi, len, warn, tag);
        send_bits(mo, mi, 0, len, len);
    endtask

    task automatic cs_set(input logic lvl);
        if (cs_present && lvl != bus_cs) begin
            qe_old.push_back(bus_cs);
            qe_new.push_back(lvl);
        end
        bus_cs = lvl;
        idle(10);
    endtask

    task automatic set_mode(input logic cpol, input logic cpha);
        cfg_cpol = cpol; cfg_cpha = cpha;
        idle(2);
        bus_sck = cpol;
        idle(8);
    endtask

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && data_valid) begin
                checks++;
                if (q_mosi.size() == 0) begin
                    failures++;
                    $display("FAIL R4 unexpected word actual=%h/%h expected none", mosi_word, miso_word);
                end else begin
                    logic [63:0] em, ei; bit ew; string tg;
                    em = q_mosi.pop_front(); ei = q_miso.pop_front();
                    ew = q_warn.pop_front(); tg = q_tag.pop_front();
                    if (mosi_word !== em || miso_word !== ei || cs_warn !== ew) begin
                        failures++;
                        $display("FAIL %s word actual=%h/%h warn=%b expected=%h/%h warn=%b",
                                 tg, mosi_word, miso_word, cs_warn, em, ei, ew);
                    end
                end
            end
            if (!rst && cs_event) begin
                checks++;
                if (qe_old.size() == 0) begin
                    failures++;
                    $display("FAIL R5 unexpected cs event actual=%b->%b expected none", cs_old, cs_new);
                end else begin
                    bit eo, en;
                    eo = qe_old.pop_front(); en = qe_new.pop_front();
                    if (cs_old !== eo || cs_new !== en) begin
                        failures++;
                        $display("FAIL R5 cs event actual=%b->%b expected=%b->%b", cs_old, cs_new, eo, en);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(1);
        // R9 reset state
        check(data_valid == 1'b0, "R9 data_valid", data_valid, 0);
        check(cs_event == 1'b0, "R9 cs_event", cs_event, 0);
        check(cs_warn == 1'b0, "R9 cs_warn", cs_warn, 0);
        check(word_count == 16'd0, "R9 word_count", word_count, 0);
        idle(10);

        cs_set(1'b0);
        // R1 mode 0, R2 both orders
        word(64'hA5, 64'h3C, 8, 1'b0, "R1_mode0");
        cfg_lsb_first = 1'b1;
        word(64'h96, 64'h0F, 8, 1'b0, "R2_lsb8");
        // R1 mode 1, 16-bit LSB first
        set_mode(1'b0, 1'b1);
        cfg_word_len = 7'd16;
        word(64'h1234, 64'hABCD, 16, 1'b0, "R1_mode1");
        // R1 mode 2, 12-bit MSB first
        cfg_lsb_first = 1'b0;
        set_mode(1'b1, 1'b0);
        cfg_word_len = 7'd12;
        word(64'hF0E, 64'h123, 12, 1'b0, "R1_mode2");
        // R1 mode 3, R3 full 64 bits
        set_mode(1'b1, 1'b1);
        cfg_word_len = 7'd64;
        word(64'hDEADBEEF_0123F00D, 64'h8000_0000_0000_0001, 64, 1'b0, "R3_mode3_len64");
        set_mode(1'b0, 1'b0);
        // R3 clamping
        cfg_word_len = 7'd0;
        word(64'h1, 64'h0, 1, 1'b0, "R3_len0");
        cfg_word_len = 7'd100;
        word(64'hC0FFEE00_55AA1234, 64'h0F0F0F0F_F0F0F0F0, 64, 1'b0, "R3_len100");
        cfg_word_len = 7'd8;
        // R10 data noise with SCK held idle
        for (int k = 0; k < 6; k++) begin
            bus_mosi = k[0]; bus_miso = ~k[0];
            idle(6);
        end
        word(64'h5A, 64'hC3, 8, 1'b0, "R10_noise");
        // R6 partial word dropped by a chip-select pulse
        send_bits(64'hFF, 64'hFF, 0, 3, 8);
        cs_set(1'b1);
        cs_set(1'b0);
        word(64'h0F, 64'hF0, 8, 1'b0, "R6_abort");
        // R7 / R8 active-low
        cs_set(1'b1);
        word(64'h11, 64'h22, 8, 1'b1, "R7_warn_low");
        cs_set(1'b0);
        word(64'h33, 64'h44, 8, 1'b0, "R8_warn_cleared");
        // R7 / R8 active-high
        cfg_cs_active_high = 1'b1;
        idle(4);
        word(64'h55, 64'h66, 8, 1'b1, "R7_warn_high");
        cs_set(1'b1);
        word(64'h77, 64'h88, 8, 1'b0, "R8_active_high_ok");
        cs_set(1'b0);
        cfg_cs_active_high = 1'b0;
        // R5 chip-select absent: no events, partial word kept, no warning
        cs_present = 1'b0;
        idle(4);
        cs_set(1'b1);
        push_word(64'hC3, 64'h3C, 8, 1'b0, "R5_absent");
        send_bits(64'hC3, 64'h3C, 0, 4, 8);
        cs_set(1'b0);
        send_bits(64'hC3, 64'h3C, 4, 4, 8);
        cs_present = 1'b1;
        idle(20);

        // R4 all words seen, counter matches
        check(q_mosi.size() == 0, "R4 pending words", q_mosi.size(), 0);
        check(qe_old.size() == 0, "R5 pending cs events", qe_old.size(), 0);
        check(word_count == 16'(words_pushed), "R4 word_count", word_count, words_pushed);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule